// File: doc/BRIEF.md
# Ping-Pong Endpoint Buffer Status Tracker

This block follows the state of two alternating data buffers that serve one bulk endpoint of a USB device controller. It shows which buffer the USB side will use next and whether each buffer holds data. The packet engine sends a pulse each time it finishes a packet into or out of the current buffer. Firmware sends a pulse for a buffer once it has refilled it or emptied it. The register then tells either side when a buffer is ready for it.

A mode input sets the direction. In upload mode (device to host), a status bit of 1 means the buffer is loaded and may be sent. A 0 means the USB side is waiting for firmware to fill it. In download mode (host to device), a 0 means the buffer is free for the USB side to write. A 1 means it still holds data that firmware has not drained. A write of 1 to bit 0 of the register restarts the flow: it resets the buffer pointer, both status bits and a small internal count of completed packets. That count is also brought out on a port.

Top module: `dbuf_status_mgr`

## Requirements
- R1: After reset, `reg_rdata` reads 00h and `pkt_cnt` reads 0.
- R2: Bits 7 to 4 and bit 0 of `reg_rdata` always read 0. Bit 3 is the current buffer, bit 2 is the status of buffer 1 and bit 1 is the status of buffer 0.
- R3: A `usb_pkt_done` pulse without a clear inverts the current-buffer bit on the following cycle.
- R4: In upload mode (`mode_upload`=1), a `usb_pkt_done` pulse sets the current buffer's status bit to 0. A `cpu_buf_done[n]` pulse sets the status bit of buffer n to 1.
- R5: In download mode (`mode_upload`=0), a `usb_pkt_done` pulse sets the current buffer's status bit to 1. A `cpu_buf_done[n]` pulse sets the status bit of buffer n to 0.
- R6: A `cpu_buf_done[n]` pulse changes only the status bit of buffer n. The other status bit and the current-buffer bit are unchanged.
- R7: Each `usb_pkt_done` pulse without a clear increments `pkt_cnt`, which saturates at 2.
- R8: A register write with data bit 0 = 1 clears the current-buffer bit, both status bits and `pkt_cnt`. This clear takes priority over any USB or CPU pulse in the same cycle.
- R9: A register write with data bit 0 = 0 changes nothing, whatever the other data bits are.
- R10: When a `usb_pkt_done` pulse and a `cpu_buf_done` pulse hit the same buffer in the same cycle, the CPU pulse sets that buffer's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_upload | input | 1 | 1 = upload (device to host), 0 = download |
| usb_pkt_done | input | 1 | Pulse: the USB side finished a packet on the current buffer |
| cpu_buf_done | input | 2 | Pulse per buffer: firmware refilled (upload) or emptied (download) it |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data; only bit 0 acts |
| reg_rdata | output | 8 | Register read value |
| pkt_cnt | output | 2 | Completed-packet count since the last clear |

## Verification
A wrong internal state shows up on `reg_rdata` one cycle after the pulse that caused it, because the read value is taken straight from the state flops. A pointer that fails to toggle puts the next packet's status on the wrong buffer. A status bit with the wrong polarity tells one side that a buffer is ready when it is not. Both appear in bits 3 to 1 at the next sample. A packet count that fails to saturate or to clear appears on `pkt_cnt` within the same single cycle.

// File: rtl/dbuf_status_mgr.sv
module dbuf_status_mgr #(
  parameter int CNT_MAX = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_upload,
  input  logic       usb_pkt_done,
  input  logic [1:0] cpu_buf_done,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [1:0] pkt_cnt
);
  localparam int CW = $clog2(CNT_MAX + 1);

  logic          cur, cur_n;
  logic [1:0]    st, st_n;
  logic [CW-1:0] cnt, cnt_n;

  wire clr = reg_wr & reg_wdata[0];

  always_comb begin
    st_n  = st;
    cur_n = cur;
    cnt_n = cnt;
    if (usb_pkt_done) begin
      st_n[cur] = ~mode_upload;
      cur_n     = ~cur;
      if (cnt != CW'(CNT_MAX)) cnt_n = cnt + 1'b1;
    end
    for (int i = 0; i < 2; i++)
      if (cpu_buf_done[i]) st_n[i] = mode_upload;
    if (clr) begin
      st_n  = '0;
      cur_n = 1'b0;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= '0;
      cur <= 1'b0;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cur <= cur_n;
      cnt <= cnt_n;
    end
  end

  assign reg_rdata = {4'b0000, cur, st[1], st[0], 1'b0};
  assign pkt_cnt   = 2'(cnt);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:4] == 4'b0000 && reg_rdata[0] == 1'b0);

  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_pkt_done && !clr) |=> reg_rdata[3] != $past(reg_rdata[3]));

  p_cpu_keeps_cur_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!usb_pkt_done && !clr) |=> $stable(reg_rdata[3]));

  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_cnt <= 2'(CNT_MAX));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (reg_rdata == 8'h00 && pkt_cnt == 2'd0));

  p_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[0] && !usb_pkt_done && cpu_buf_done == 2'b00)
      |=> ($stable(reg_rdata) && $stable(pkt_cnt)));
endmodule

// File: tb/dbuf_status_mgr_bench.sv
module dbuf_status_mgr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_upload = 1'b0;
  logic       usb_pkt_done = 1'b0;
  logic [1:0] cpu_buf_done = 2'b00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] pkt_cnt;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dbuf_status_mgr u_dbuf_status_mgr (
    .clk(clk), .rst_n(rst_n), .mode_upload(mode_upload),
    .usb_pkt_done(usb_pkt_done), .cpu_buf_done(cpu_buf_done),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pkt_cnt(pkt_cnt)
  );

  // {mode, usb, cpu[1:0], clr, exp_cur, exp_st[1:0], exp_cnt[1:0]}
  localparam int N = 14;
  localparam logic [9:0] VEC [N] = '{
    10'b1_0_01_0_0_01_00,  // R4 R6 upload fill buf0
    10'b1_0_10_0_0_11_00,  // R4 R6 upload fill buf1
    10'b1_1_00_0_1_10_01,  // R3 R4 R7 send buf0
    10'b1_1_00_0_0_00_10,  // R3 R4 R7 send buf1
    10'b1_1_00_0_1_00_10,  // R7 saturate
    10'b1_0_00_1_0_00_00,  // R8 clear
    10'b0_1_00_0_1_01_01,  // R5 download receive buf0
    10'b0_1_01_0_0_10_10,  // R5 receive buf1, drain buf0
    10'b0_1_01_0_1_10_10,  // R10 conflict on buf0, CPU wins
    10'b0_1_00_1_0_00_00,  // R8 clear beats USB
    10'b0_1_00_0_1_01_01,  // R5 receive buf0
    10'b0_0_01_0_1_00_01,  // R5 R6 drain buf0
    10'b1_0_11_0_1_11_01,  // R4 fill both
    10'b1_1_10_0_0_11_10   // R10 upload conflict on buf1
  };

  task automatic check(input string req, input logic [7:0] act_r, input logic [7:0] exp_r,
                       input logic [1:0] act_c, input logic [1:0] exp_c);
    checks++;
    if (act_r !== exp_r || act_c !== exp_c) begin
      failures++;
      $display("FAIL %s: rdata=%h cnt=%0d expected rdata=%h cnt=%0d",
               req, act_r, act_c, exp_r, exp_c);
    end
  endtask

  task automatic step(input logic m, input logic u, input logic [1:0] c,
                      input logic w, input logic [7:0] d);
    mode_upload = m; usb_pkt_done = u; cpu_buf_done = c; reg_wr = w; reg_wdata = d;
    @(negedge clk);
    usb_pkt_done = 1'b0; cpu_buf_done = 2'b00; reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] held;
    logic [1:0] held_c;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset", reg_rdata, 8'h00, pkt_cnt, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", reg_rdata, 8'h00, pkt_cnt, 2'd0);

    for (int i = 0; i < N; i++) begin
      logic [9:0] v;
      v = VEC[i];
      step(v[9], v[8], v[7:6], v[5], v[5] ? 8'h01 : 8'h00);
      check($sformatf("R3-R10 vector %0d", i), reg_rdata,
            {4'b0000, v[4], v[3], v[2], 1'b0}, pkt_cnt, v[1:0]);
    end

    held = reg_rdata;
    held_c = pkt_cnt;
    step(1'b1, 1'b0, 2'b00, 1'b1, 8'hFE);
    check("R9 write bit0=0", reg_rdata, held, pkt_cnt, held_c);
    check("R2 reserved bits", reg_rdata & 8'hF1, 8'h00, 2'd0, 2'd0);

    step(1'b1, 1'b0, 2'b00, 1'b1, 8'hFF);
    check("R8 write FFh clears", reg_rdata, 8'h00, pkt_cnt, 2'd0);

    step(1'b0, 1'b0, 2'b10, 1'b0, 8'h00);
    check("R6 R5 drain idle buf1", reg_rdata, 8'h00, pkt_cnt, 2'd0);
    step(1'b1, 1'b0, 2'b10, 1'b0, 8'h00);
    check("R6 R4 fill buf1 only", reg_rdata, 8'h04, pkt_cnt, 2'd0);
    step(1'b1, 1'b0, 2'b11, 1'b1, 8'h01);
    check("R8 clear beats CPU", reg_rdata, 8'h00, pkt_cnt, 2'd0);

    step(1'b0, 1'b1, 2'b00, 1'b0, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", reg_rdata, 8'h00, pkt_cnt, 2'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule